// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This combinational unit sits beside the execute stage of a five-stage in-order pipeline and removes read-after-write hazards. For each of the two ALU operands of the instruction now in execute, it checks the two source register numbers against the destinations of the two older instructions. Those instructions are in the memory and write-back stages. From that check it picks where the operand comes from: the register file, the memory-stage ALU result or the write-back value.

Some hazards cannot be bypassed in time. If the instruction in execute is a load, and its target register is one of the sources of the instruction being decoded, the unit requests a one-cycle interlock. It holds the program counter, holds the fetch/decode register and asks for the decode-stage control word to be replaced by zeros. That zero control word is a bubble. On the next cycle the loaded value sits in write-back and reaches the dependent instruction through the normal bypass path. The instruction that follows the dependent one is fetched a second time, because the program counter did not advance.

Top module: `hazard_bypass_ctl`

## Requirements
- R1: `byp_a` is 2'b10 (memory-stage result) when `mem_wr` is 1, `mem_dst` is not 0 and `mem_dst` equals `ex_src_a`.
- R2: `byp_a` is 2'b01 (write-back value) when `wb_wr` is 1, `wb_dst` is not 0, `wb_dst` equals `ex_src_a`, and the R1 condition does not hold.
- R3: When the memory-stage and write-back-stage matches both hold for an operand, the memory-stage source (2'b10) wins.
- R4: A source register number of 0 is never bypassed: its select stays 2'b00 whatever the older destinations are.
- R5: A destination match with its write enable at 0 has no effect on the select. With no qualifying match the select is 2'b00 (register file), and 2'b11 is never produced.
- R6: `byp_b` obeys R1 to R5 with `ex_src_b` in place of `ex_src_a`, independently of `byp_a`.
- R7: When `ex_load` is 1 and `ex_src_b` (the load's target) equals `id_src_a` or `id_src_b`, `pc_en` is 0, `ifid_en` is 0 and `bubble` is 1. The comparison is on register numbers only, register 0 included.
- R8: In every other case `pc_en` is 1, `ifid_en` is 1 and `bubble` is 0. This includes a target match while `ex_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | RW | First source register number of the instruction in execute |
| ex_src_b | input | RW | Second source register number of the instruction in execute; for a load, its target |
| ex_load | input | 1 | Instruction in execute reads data memory |
| mem_dst | input | RW | Destination register of the instruction in the memory stage |
| mem_wr | input | 1 | Memory-stage instruction writes the register file |
| wb_dst | input | RW | Destination register of the instruction in write-back |
| wb_wr | input | 1 | Write-back instruction writes the register file |
| id_src_a | input | RW | First source register number of the instruction being decoded |
| id_src_b | input | RW | Second source register number of the instruction being decoded |
| byp_a | output | 2 | First ALU operand select: 00 register file, 10 memory-stage result, 01 write-back value |
| byp_b | output | 2 | Second ALU operand select, same encoding |
| pc_en | output | 1 | Program counter write enable |
| ifid_en | output | 1 | Fetch/decode pipeline register write enable |
| bubble | output | 1 | Request to zero the decode-stage control word |

## Verification
Every output is a pure function of the current inputs with no register on the path. Each result is therefore due in the same cycle as its stimulus. The driver applies one input pattern on each rising bench-clock edge and queues the expected selects and enables computed from the requirements. The monitor pops one entry on the following falling edge, half a period after the inputs settle and before the next pattern, so each comparison sees only the stimulus it belongs to.

// File: rtl/hazard_bypass_ctl.sv
module hazard_bypass_ctl #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  output logic [1:0]    byp_a,
  output logic [1:0]    byp_b,
  output logic          pc_en,
  output logic          ifid_en,
  output logic          bubble
);

  localparam logic [RW-1:0] R_ZERO = '0;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;

  logic mem_live, wb_live;
  assign mem_live = mem_wr && (mem_dst != R_ZERO);
  assign wb_live  = wb_wr  && (wb_dst  != R_ZERO);

  function automatic logic [1:0] pick(input logic [RW-1:0] src,
                                      input logic ml, input logic [RW-1:0] md,
                                      input logic wl, input logic [RW-1:0] wd);
    if (ml && md == src)      return SEL_MEM;
    else if (wl && wd == src) return SEL_WB;
    else                      return SEL_RF;
  endfunction

  assign byp_a = pick(ex_src_a, mem_live, mem_dst, wb_live, wb_dst);
  assign byp_b = pick(ex_src_b, mem_live, mem_dst, wb_live, wb_dst);

  logic hold;
  assign hold    = ex_load && ((ex_src_b == id_src_a) || (ex_src_b == id_src_b));
  assign pc_en   = !hold;
  assign ifid_en = !hold;
  assign bubble  = hold;

  always_comb begin
    a_r5_no_illegal_sel: assert (byp_a != 2'b11 && byp_b != 2'b11);
    a_r4_zero_src_a: assert (ex_src_a != R_ZERO || byp_a == SEL_RF);
    a_r4_zero_src_b: assert (ex_src_b != R_ZERO || byp_b == SEL_RF);
    a_r1_mem_needs_wr: assert (byp_a != SEL_MEM || (mem_wr && mem_dst == ex_src_a));
    a_r2_wb_needs_wr: assert (byp_a != SEL_WB || (wb_wr && wb_dst == ex_src_a));
    a_r6_mem_needs_wr_b: assert (byp_b != SEL_MEM || (mem_wr && mem_dst == ex_src_b));
    a_r3_wb_only_without_mem: assert (byp_b != SEL_WB || !(mem_wr && mem_dst == ex_src_b && mem_dst != R_ZERO));
    a_r7_hold_coherent: assert (pc_en == ifid_en && bubble == !pc_en);
    a_r8_hold_needs_load: assert (pc_en || ex_load);
  end

endmodule

// File: tb/sim_hazard_bypass_ctl.sv
module sim_hazard_bypass_ctl;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [RW-1:0] ex_src_a = '0, ex_src_b = '0, mem_dst = '0, wb_dst = '0;
  logic [RW-1:0] id_src_a = '0, id_src_b = '0;
  logic ex_load = 1'b0, mem_wr = 1'b0, wb_wr = 1'b0;
  logic [1:0] byp_a, byp_b;
  logic pc_en, ifid_en, bubble;

  hazard_bypass_ctl #(.RW(RW)) u0 (
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .wb_dst(wb_dst), .wb_wr(wb_wr),
    .id_src_a(id_src_a), .id_src_b(id_src_b),
    .byp_a(byp_a), .byp_b(byp_b), .pc_en(pc_en), .ifid_en(ifid_en), .bubble(bubble));

  logic [6:0] exp_q[$];
  string      tag_q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  function automatic logic [1:0] ref_sel(logic [RW-1:0] s);
    if (s != 0 && mem_wr && mem_dst == s) return 2'b10;
    if (s != 0 && wb_wr && wb_dst == s)   return 2'b01;
    return 2'b00;
  endfunction

  task automatic apply(input logic [RW-1:0] ea, eb, input logic ld,
                       input logic [RW-1:0] md, input logic mw,
                       input logic [RW-1:0] wd, input logic ww,
                       input logic [RW-1:0] ia, ib, input string tag);
    logic st;
    @(posedge clk);
    ex_src_a = ea; ex_src_b = eb; ex_load = ld;
    mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
    id_src_a = ia; id_src_b = ib;
    st = ld && (eb == ia || eb == ib);
    exp_q.push_back({ref_sel(ea), ref_sel(eb), !st, !st, st});
    tag_q.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [6:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {byp_a, byp_b, pc_en, ifid_en, bubble};
      n_chk++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %b expected %b", t, a, e);
      end
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_up();
    end
  end

  initial begin
    apply(0, 0, 0, 0, 0, 0, 0, 1, 2, "R8 idle state");
    apply(3, 4, 0, 3, 1, 0, 0, 9, 9, "R1 mem to a");
    apply(3, 4, 0, 9, 1, 3, 1, 9, 9, "R2 wb to a");
    apply(7, 4, 0, 7, 1, 7, 1, 9, 9, "R3 mem beats wb on a");
    apply(5, 7, 0, 7, 1, 7, 1, 9, 9, "R3 mem beats wb on b R6");
    apply(0, 0, 0, 0, 1, 0, 1, 9, 9, "R4 register 0 not bypassed");
    apply(6, 8, 0, 6, 0, 8, 0, 9, 9, "R5 write enables low");
    apply(6, 8, 0, 6, 0, 6, 1, 9, 9, "R5 mem disabled falls to wb");
    apply(2, 11, 0, 11, 1, 2, 1, 9, 9, "R6 independent selects");
    apply(12, 12, 0, 12, 1, 0, 0, 1, 2, "R6 same source both operands");
    apply(1, 4, 1, 0, 0, 0, 0, 4, 9, "R7 load target vs id a");
    apply(1, 4, 1, 0, 0, 0, 0, 9, 4, "R7 load target vs id b");
    apply(1, 0, 1, 0, 0, 0, 0, 0, 9, "R7 register 0 still compared");
    apply(1, 4, 0, 0, 0, 0, 0, 4, 4, "R8 match without load");
    apply(1, 4, 1, 0, 0, 0, 0, 5, 6, "R8 load without match");
    apply(2, 4, 1, 2, 1, 4, 1, 4, 2, "R7 stall with forwarding R1 R2");
    apply(31, 30, 0, 30, 1, 31, 1, 30, 31, "R1 R2 top register numbers");
    @(posedge clk);
    @(posedge clk);
    done = 1;
    finish_up();
  end
endmodule